// File: doc/BRIEF.md
# UART Task-Event Control Front-End

This block is the register-side controller of a simple UART. Software uses it through a word-addressed 32-bit bus with single-cycle write and read strobes. Writing a command word to a task register starts or stops the transmitter and the receiver. Status is latched in one-bit event flags. An interrupt mask decides which of those flags raise the single level interrupt. Nothing inside the peripheral responds until software writes the unlock key to the enable register.

The bit-level serializer and deserializer are outside this block, and so is the baud generator. They connect through four signals:

- a byte and load strobe for transmission;
- a pulse when a transmitted byte has left;
- a pulse when a line break is seen;
- a byte with a valid pulse when a received byte arrives.

Received bytes wait in a small FIFO and are popped by reading the receive-data word. Configuration words for line pin selection and bit rate are held with their defined reset values for the neighbouring logic.

Top module: `uctl_top`

## Requirements
- R1: While disabled, every read returns 0 one cycle after the read strobe. Every write is ignored except a write to the enable word (index 0x140).
- R2: Writing 4 to the enable word enables the block, and a read of the enable word then returns 4. Any other nonzero value changes nothing.
- R3: Writing 0 to the enable word disables the block, clears both started flags and sets the receive-timeout event.
- R4: The start-receive task (index 0x000) and the start-transmit task (index 0x002) set their started flag only when the written value is exactly 1.
- R5: The three stop tasks act only on a written value of 1.
  - Stop-receive (index 0x001) clears the receiver flag and sets receive-timeout.
  - Stop-transmit (index 0x003) clears only the transmitter flag.
  - Suspend (index 0x007) clears both flags and sets receive-timeout.
- R6: The interrupt output is registered. It goes high one cycle after any event flag is set whose mask bit is also set, and low one cycle after no masked flag remains. The events and their mask bits are: receive-ready (event index 0x042) at bit 2, transmit-ready (0x047) at bit 7, error (0x049) at bit 9, and receive-timeout (0x051) at bit 17.
- R7: The mask word has three write indices:
  - 0x0C0 replaces the mask;
  - 0x0C1 ORs the written value into the mask;
  - 0x0C2 clears the mask bits that are 1 in the written value.
  A read of any of the three returns the mask.
- R8: A break pulse sets bits 1:0 of the error-source word (index 0x120) and sets the error event. Writing to the error-source word clears the bits written as 1.
- R9: A write to the transmit-data word (index 0x147) is accepted only while the transmitter is started and no byte is pending. An accepted write presents the low byte on the TXD output, pulses the load strobe for one cycle and marks the byte pending. A transmit-done pulse while a byte is pending clears the pending mark and sets transmit-ready.
- R10: An arriving byte is stored only while the receiver is started and the FIFO holds fewer than RX_DEPTH bytes. A stored byte sets receive-ready. A read of the receive-data word (index 0x146) returns the oldest byte and removes it. The read sets receive-ready again if bytes remain.
- R11: After reset, every register reads 0 except two groups:
  - the four pin-select words (indices 0x142 to 0x145) read 0xFFFFFFFF;
  - the bit-rate word (index 0x149) reads 0x04000000.
- R12: Software may write an event word directly: a zero clears the flag and a nonzero value sets it. An event word reads 1 or 0. A set from the hardware side wins over a software write in the same cycle.
- R13: Task words read 0. Unmapped indices ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 10 | Word index of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_o | output | 1 | Level interrupt |
| tx_started_o | output | 1 | Transmitter started flag |
| rx_started_o | output | 1 | Receiver started flag |
| txd_byte_o | output | 8 | Byte handed to the serializer |
| txd_load_o | output | 1 | One-cycle load strobe for txd_byte_o |
| tx_done_i | input | 1 | Pulse: pending byte finished |
| brk_i | input | 1 | Pulse: line break detected |
| rx_valid_i | input | 1 | Pulse: received byte present |
| rx_byte_i | input | 8 | Received byte |

## Verification
The results of this block become visible on two different schedules:

- **One clock edge after the stimulus.** This covers the started flags, the event flags, the mask, the TXD byte and its load strobe. It also covers read data, which is captured at the edge that samples bus_rd.
- **Two clock edges after the stimulus.** The interrupt output needs a second edge because it is registered from the event flags.

The bench drives every stimulus half a cycle before an edge. Flags and the load strobe are sampled at the falling edge that follows the write. The interrupt is sampled one full cycle later. Each read pushes its expected word into a queue, and a monitor pops that entry at the falling edge after the capture edge.

// File: rtl/uctl_pkg.sv
package uctl_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int EV_N   = 4;
  localparam int PIN_N  = 4;

  typedef logic [ADDR_W-1:0] waddr_t;
  typedef logic [DATA_W-1:0] word_t;

  // task words
  localparam waddr_t A_RX_GO     = 10'h000;
  localparam waddr_t A_RX_HALT   = 10'h001;
  localparam waddr_t A_TX_GO     = 10'h002;
  localparam waddr_t A_TX_HALT   = 10'h003;
  localparam waddr_t A_PAUSE     = 10'h007;
  // event words
  localparam waddr_t A_EV_RXRDY  = 10'h042;
  localparam waddr_t A_EV_TXRDY  = 10'h047;
  localparam waddr_t A_EV_ERR    = 10'h049;
  localparam waddr_t A_EV_RXTO   = 10'h051;
  // mask words
  localparam waddr_t A_MASK      = 10'h0C0;
  localparam waddr_t A_MASK_OR   = 10'h0C1;
  localparam waddr_t A_MASK_ANDN = 10'h0C2;
  // other words
  localparam waddr_t A_ERRSRC    = 10'h120;
  localparam waddr_t A_ENA       = 10'h140;
  localparam waddr_t A_PIN0      = 10'h142;
  localparam waddr_t A_RXD       = 10'h146;
  localparam waddr_t A_TXD       = 10'h147;
  localparam waddr_t A_RATE      = 10'h149;

  localparam word_t ENA_KEY  = 32'd4;
  localparam word_t PIN_RST  = 32'hFFFF_FFFF;
  localparam word_t RATE_RST = 32'h0400_0000;

  // event slots
  localparam int EV_RXRDY = 0;
  localparam int EV_TXRDY = 1;
  localparam int EV_ERR   = 2;
  localparam int EV_RXTO  = 3;

  function automatic int ev_mask_bit(input int slot);
    case (slot)
      EV_RXRDY: return 2;
      EV_TXRDY: return 7;
      EV_ERR:   return 9;
      default:  return 17;
    endcase
  endfunction

  function automatic waddr_t ev_addr(input int slot);
    case (slot)
      EV_RXRDY: return A_EV_RXRDY;
      EV_TXRDY: return A_EV_TXRDY;
      EV_ERR:   return A_EV_ERR;
      default:  return A_EV_RXTO;
    endcase
  endfunction
endpackage

// File: rtl/uctl_ctrl.sv
module uctl_ctrl
  import uctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_ok,
  input  waddr_t addr,
  input  word_t  wdata,
  output logic   en_q,
  output logic   tx_on_q,
  output logic   rx_on_q,
  output logic   rxto_set
);
  logic one_w, zero_w, key_w;
  logic go_tx, go_rx, halt_tx, halt_rx, ena_on, ena_off;

  assign one_w  = (wdata == word_t'(1));
  assign zero_w = (wdata == '0);
  assign key_w  = (wdata == ENA_KEY);

  always_comb begin
    go_tx   = 1'b0;
    go_rx   = 1'b0;
    halt_tx = 1'b0;
    halt_rx = 1'b0;
    ena_on  = 1'b0;
    ena_off = 1'b0;
    if (wr_ok) begin
      case (addr)
        A_TX_GO:   go_tx = one_w;
        A_RX_GO:   go_rx = one_w;
        A_TX_HALT: halt_tx = one_w;
        A_RX_HALT: halt_rx = one_w;
        A_PAUSE: begin
          halt_tx = one_w;
          halt_rx = one_w;
        end
        A_ENA: begin
          ena_on  = key_w;
          ena_off = zero_w;
          halt_tx = zero_w;
          halt_rx = zero_w;
        end
        default: ;
      endcase
    end
  end

  assign rxto_set = halt_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      tx_on_q <= 1'b0;
      rx_on_q <= 1'b0;
    end else begin
      if (ena_on)       en_q <= 1'b1;
      else if (ena_off) en_q <= 1'b0;
      if (halt_tx)      tx_on_q <= 1'b0;
      else if (go_tx)   tx_on_q <= 1'b1;
      if (halt_rx)      rx_on_q <= 1'b0;
      else if (go_rx)   rx_on_q <= 1'b1;
    end
  end
endmodule

// File: rtl/uctl_evt.sv
module uctl_evt
  import uctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [EV_N-1:0] hw_set,
  input  logic [EV_N-1:0] sw_wr,
  input  logic            sw_val,
  input  logic            mask_load,
  input  logic            mask_or,
  input  logic            mask_andn,
  input  logic            src_w1c,
  input  logic            brk,
  input  word_t           wdata,
  output logic [EV_N-1:0] ev_q,
  output word_t           mask_q,
  output logic [1:0]      src_q,
  output logic            irq_q
);
  logic [EV_N-1:0] qual;

  for (genvar g = 0; g < EV_N; g++) begin : g_ev
    always_ff @(posedge clk) begin
      if (rst)            ev_q[g] <= 1'b0;
      else if (hw_set[g]) ev_q[g] <= 1'b1;
      else if (sw_wr[g])  ev_q[g] <= sw_val;
    end
    assign qual[g] = ev_q[g] & mask_q[ev_mask_bit(g)];
  end

  always_ff @(posedge clk) begin
    if (rst)            mask_q <= '0;
    else if (mask_load) mask_q <= wdata;
    else if (mask_or)   mask_q <= mask_q | wdata;
    else if (mask_andn) mask_q <= mask_q & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= (src_q & ~(src_w1c ? wdata[1:0] : 2'b00)) | {2{brk}};
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |qual;
  end
endmodule

// File: rtl/uctl_rxfifo.sv
module uctl_rxfifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          allow,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          more_left
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok   = push & allow & (count < CW'(DEPTH));
  assign pop_ok    = pop & allow & (count != '0);
  assign more_left = (count > CW'(1));
  assign head      = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uctl_top.sv
module uctl_top
  import uctl_pkg::*;
#(
  parameter int RX_DEPTH = 4,
  localparam int CW = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              tx_started_o,
  output logic              rx_started_o,
  output logic [BYTE_W-1:0] txd_byte_o,
  output logic              txd_load_o,
  input  logic              tx_done_i,
  input  logic              brk_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i
);
  logic            en_q, tx_on, rx_on, rxto_set;
  logic            wr_ok, rd_ok;
  logic [EV_N-1:0] ev_q, hw_set, sw_wr;
  word_t           mask_q;
  logic [1:0]      src_q;
  logic            irq_q;
  logic [BYTE_W-1:0] rx_head;
  logic [CW-1:0]   rx_count;
  logic            push_ok, pop_ok, more_left;
  logic            tx_pend_q, tx_take, tx_fin;
  word_t           pin_q [PIN_N];
  word_t           rate_q;
  word_t           rmux;

  assign wr_ok = bus_wr & (en_q | (bus_addr == A_ENA));
  assign rd_ok = bus_rd & en_q;

  uctl_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .addr(bus_addr), .wdata(bus_wdata),
    .en_q(en_q), .tx_on_q(tx_on), .rx_on_q(rx_on), .rxto_set(rxto_set)
  );

  uctl_rxfifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) u_rxq (
    .clk(clk), .rst(rst), .allow(rx_on), .push(rx_valid_i), .din(rx_byte_i),
    .pop(rd_ok && (bus_addr == A_RXD)), .head(rx_head), .count(rx_count),
    .push_ok(push_ok), .pop_ok(pop_ok), .more_left(more_left)
  );

  // transmit handoff
  assign tx_take = wr_ok && (bus_addr == A_TXD) && tx_on && !tx_pend_q;
  assign tx_fin  = tx_done_i && tx_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pend_q  <= 1'b0;
      txd_byte_o <= '0;
      txd_load_o <= 1'b0;
    end else begin
      txd_load_o <= tx_take;
      if (tx_take) begin
        tx_pend_q  <= 1'b1;
        txd_byte_o <= bus_wdata[BYTE_W-1:0];
      end else if (tx_fin) begin
        tx_pend_q  <= 1'b0;
      end
    end
  end

  // event sources
  always_comb begin
    hw_set           = '0;
    hw_set[EV_RXRDY] = push_ok | (pop_ok & more_left);
    hw_set[EV_TXRDY] = tx_fin;
    hw_set[EV_ERR]   = brk_i;
    hw_set[EV_RXTO]  = rxto_set;
  end

  for (genvar g = 0; g < EV_N; g++) begin : g_swr
    assign sw_wr[g] = wr_ok && (bus_addr == ev_addr(g));
  end

  uctl_evt u_evt (
    .clk(clk), .rst(rst), .hw_set(hw_set), .sw_wr(sw_wr), .sw_val(|bus_wdata),
    .mask_load(wr_ok && (bus_addr == A_MASK)),
    .mask_or(wr_ok && (bus_addr == A_MASK_OR)),
    .mask_andn(wr_ok && (bus_addr == A_MASK_ANDN)),
    .src_w1c(wr_ok && (bus_addr == A_ERRSRC)), .brk(brk_i), .wdata(bus_wdata),
    .ev_q(ev_q), .mask_q(mask_q), .src_q(src_q), .irq_q(irq_q)
  );
  assign irq_o        = irq_q;
  assign tx_started_o = tx_on;
  assign rx_started_o = rx_on;

  // configuration words
  for (genvar p = 0; p < PIN_N; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) pin_q[p] <= PIN_RST;
      else if (wr_ok && (bus_addr == A_PIN0 + waddr_t'(p))) pin_q[p] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rate_q <= RATE_RST;
    else if (wr_ok && (bus_addr == A_RATE)) rate_q <= bus_wdata;
  end

  // read path
  always_comb begin
    rmux = '0;
    case (bus_addr)
      A_EV_RXRDY: rmux = word_t'(ev_q[EV_RXRDY]);
      A_EV_TXRDY: rmux = word_t'(ev_q[EV_TXRDY]);
      A_EV_ERR:   rmux = word_t'(ev_q[EV_ERR]);
      A_EV_RXTO:  rmux = word_t'(ev_q[EV_RXTO]);
      A_MASK, A_MASK_OR, A_MASK_ANDN: rmux = mask_q;
      A_ERRSRC:   rmux = word_t'(src_q);
      A_ENA:      rmux = ENA_KEY;
      A_RXD:      rmux = word_t'(rx_head);
      A_TXD:      rmux = word_t'(txd_byte_o);
      A_RATE:     rmux = rate_q;
      default: begin
        for (int p = 0; p < PIN_N; p++)
          if (bus_addr == A_PIN0 + waddr_t'(p)) rmux = pin_q[p];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_ok ? rmux : '0;
  end
endmodule

// File: rtl/uctl_chk.sv
module uctl_chk
  import uctl_pkg::*;
#(
  parameter int RX_DEPTH = 4,
  localparam int CW = $clog2(RX_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              en_q,
  input logic              tx_started_o,
  input logic              rx_started_o,
  input logic              txd_load_o,
  input logic [CW-1:0]     rx_count
);
  // R1
  a_r1_off_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !en_q) |=> (bus_rdata == '0));

  // R2
  a_r2_bad_key_stays_off: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !en_q && bus_addr == A_ENA && bus_wdata != ENA_KEY) |=> !en_q);

  // R3
  a_r3_off_stops_both: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_ENA && bus_wdata == '0) |=>
      (!en_q && !tx_started_o && !rx_started_o));

  // R4
  a_r4_tx_go_exact: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && en_q && bus_addr == A_TX_GO && bus_wdata != 32'd1 && !tx_started_o)
      |=> !tx_started_o);

  // R9
  a_r9_load_needs_start: assert property (@(posedge clk) disable iff (rst)
    txd_load_o |-> $past(tx_started_o));

  // R10
  a_r10_fifo_bound: assert property (@(posedge clk) disable iff (rst)
    rx_count <= CW'(RX_DEPTH));
endmodule

bind uctl_top uctl_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_q(en_q),
  .tx_started_o(tx_started_o), .rx_started_o(rx_started_o),
  .txd_load_o(txd_load_o), .rx_count(rx_count)
);

// File: tb/tb_uctl_top.sv
module tb_uctl_top;
  import uctl_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, tx_started_o, rx_started_o, txd_load_o;
  logic [7:0]  txd_byte_o;
  logic        tx_done_i = 1'b0, brk_i = 1'b0, rx_valid_i = 1'b0;
  logic [7:0]  rx_byte_i = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic rd_pend = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  uctl_top dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .tx_started_o(tx_started_o), .rx_started_o(rx_started_o),
    .txd_byte_o(txd_byte_o), .txd_load_o(txd_load_o), .tx_done_i(tx_done_i),
    .brk_i(brk_i), .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: pushes the expected word, monitor compares it
  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done_i = 1'b1;
    @(negedge clk); tx_done_i = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk); brk_i = 1'b1;
    @(negedge clk); brk_i = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk); rx_valid_i = 1'b1; rx_byte_i = b;
    @(negedge clk); rx_valid_i = 1'b0;
  endtask

  always @(posedge clk) rd_pend <= bus_rd;

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, bus_rdata, e);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick();
    chk("R11 reset irq", {31'b0, irq_o}, 0);
    chk("R11 reset tx flag", {31'b0, tx_started_o}, 0);
    chk("R11 reset rx flag", {31'b0, rx_started_o}, 0);
    chk("R11 reset load", {31'b0, txd_load_o}, 0);

    // R1: disabled
    wr(A_TX_GO, 1);
    chk("R1 task ignored while off", {31'b0, tx_started_o}, 0);
    rd(A_PIN0, 0, "R1 read zero while off");
    rd(A_ENA, 0, "R1 enable reads zero while off");
    // R2: wrong key
    wr(A_ENA, 5);
    rd(A_RATE, 0, "R2 bad key keeps off");
    wr(A_ENA, 4);
    rd(A_ENA, 4, "R2 enable reads key");
    // R11 reset values
    for (int p = 0; p < 4; p++) rd(A_PIN0 + 10'(p), 32'hFFFF_FFFF, "R11 pin select");
    rd(A_RATE, 32'h0400_0000, "R11 rate");
    rd(A_MASK, 0, "R11 mask");
    rd(A_ERRSRC, 0, "R11 error source");

    // R4: exact 1
    wr(A_TX_GO, 2);
    chk("R4 start tx with 2", {31'b0, tx_started_o}, 0);
    wr(A_TX_GO, 1);
    chk("R4 start tx with 1", {31'b0, tx_started_o}, 1);
    wr(A_RX_GO, 3);
    chk("R4 start rx with 3", {31'b0, rx_started_o}, 0);
    wr(A_RX_GO, 1);
    chk("R4 start rx with 1", {31'b0, rx_started_o}, 1);

    // R13
    rd(A_TX_GO, 0, "R13 task reads zero");
    wr(10'h3FF, 32'hDEAD_BEEF);
    rd(10'h3FF, 0, "R13 unmapped reads zero");

    // R7: mask aliases
    wr(A_MASK, 32'h84);
    rd(A_MASK_OR, 32'h84, "R7 load");
    wr(A_MASK_OR, 32'h200);
    rd(A_MASK, 32'h284, "R7 or alias");
    wr(A_MASK_ANDN, 32'h4);
    rd(A_MASK_ANDN, 32'h280, "R7 clear alias");

    // R9: transmit handoff
    wr(A_TXD, 32'h15A);
    chk("R9 load strobe", {31'b0, txd_load_o}, 1);
    chk("R9 byte", {24'b0, txd_byte_o}, 32'h5A);
    tick();
    chk("R9 strobe one cycle", {31'b0, txd_load_o}, 0);
    wr(A_TXD, 32'h33);
    chk("R9 pending blocks load", {31'b0, txd_load_o}, 0);
    chk("R9 pending keeps byte", {24'b0, txd_byte_o}, 32'h5A);
    pulse_done();
    rd(A_EV_TXRDY, 1, "R9 done sets tx ready");
    tick();
    chk("R6 irq from tx ready", {31'b0, irq_o}, 1);
    wr(A_EV_TXRDY, 0);
    tick();
    chk("R12 clear event drops irq", {31'b0, irq_o}, 0);
    rd(A_EV_TXRDY, 0, "R12 event reads zero");
    wr(A_TXD, 32'h33);
    chk("R9 accepted after done", {24'b0, txd_byte_o}, 32'h33);

    // R8: break and error source
    pulse_brk();
    rd(A_ERRSRC, 3, "R8 break sets source");
    rd(A_EV_ERR, 1, "R8 break sets error");
    chk("R6 irq from error", {31'b0, irq_o}, 1);
    wr(A_ERRSRC, 1);
    rd(A_ERRSRC, 2, "R8 w1c bit0");
    wr(A_ERRSRC, 2);
    rd(A_ERRSRC, 0, "R8 w1c bit1");
    wr(A_EV_ERR, 0);
    tick();
    chk("R6 irq low", {31'b0, irq_o}, 0);

    // R12: direct set
    wr(A_EV_TXRDY, 32'h10);
    rd(A_EV_TXRDY, 1, "R12 nonzero sets event");
    chk("R6 irq from direct set", {31'b0, irq_o}, 1);
    wr(A_EV_TXRDY, 0);

    // R10: receive FIFO
    push_byte(8'h11);
    push_byte(8'h22);
    rd(A_EV_RXRDY, 1, "R10 arrival sets rx ready");
    chk("R6 masked-off event keeps irq low", {31'b0, irq_o}, 0);
    wr(A_EV_RXRDY, 0);
    rd(A_RXD, 32'h11, "R10 first byte");
    rd(A_EV_RXRDY, 1, "R10 rearm when bytes remain");
    wr(A_EV_RXRDY, 0);
    rd(A_RXD, 32'h22, "R10 second byte");
    rd(A_EV_RXRDY, 0, "R10 no rearm when empty");
    for (int i = 0; i < 5; i++) push_byte(8'hC0 + 8'(i));
    rd(A_RXD, 32'hC0, "R10 full order 0");
    rd(A_RXD, 32'hC1, "R10 full order 1");
    rd(A_RXD, 32'hC2, "R10 full order 2");
    wr(A_EV_RXRDY, 0);
    rd(A_RXD, 32'hC3, "R10 full order 3");
    rd(A_EV_RXRDY, 0, "R10 byte beyond depth dropped");

    // R5: stop tasks
    wr(A_TX_HALT, 1);
    chk("R5 stop tx clears tx", {31'b0, tx_started_o}, 0);
    chk("R5 stop tx keeps rx", {31'b0, rx_started_o}, 1);
    rd(A_EV_RXTO, 0, "R5 stop tx no timeout");
    wr(A_RX_HALT, 2);
    chk("R5 stop rx needs 1", {31'b0, rx_started_o}, 1);
    wr(A_RX_HALT, 1);
    chk("R5 stop rx clears rx", {31'b0, rx_started_o}, 0);
    rd(A_EV_RXTO, 1, "R5 stop rx sets timeout");
    wr(A_EV_RXTO, 0);
    push_byte(8'h77);
    wr(A_RX_GO, 1);
    rd(A_EV_RXRDY, 0, "R10 arrival ignored while stopped");
    wr(A_TX_GO, 1);
    wr(A_MASK_OR, 32'h2_0000);
    wr(A_PAUSE, 1);
    chk("R5 suspend clears tx", {31'b0, tx_started_o}, 0);
    chk("R5 suspend clears rx", {31'b0, rx_started_o}, 0);
    tick();
    chk("R6 irq from timeout", {31'b0, irq_o}, 1);
    rd(A_EV_RXTO, 1, "R5 suspend sets timeout");

    // R3: disable sequence
    wr(A_TX_GO, 1);
    wr(A_RX_GO, 1);
    wr(A_EV_RXTO, 0);
    wr(A_ENA, 0);
    chk("R3 off clears tx", {31'b0, tx_started_o}, 0);
    chk("R3 off clears rx", {31'b0, rx_started_o}, 0);
    rd(A_EV_RXTO, 0, "R1 event read zero while off");
    wr(A_MASK, 0);
    wr(A_ENA, 4);
    rd(A_EV_RXTO, 1, "R3 off sets timeout");
    rd(A_MASK, 32'h2_0280, "R1 write ignored while off");

    tick();
    tick();
    done = 1;
    finish_run();
  end
endmodule